// File: doc/BRIEF.md
# APB Register Read Capture

This debug helper issues single read transactions on an APB bus when asked, and it keeps the results in a small memory so they can be inspected later. A rising edge on the start input launches one read of a 24-bit target address. The block runs the usual two-phase bus handshake and waits out any slave wait states. When the slave completes, the returned 32-bit word and the address that produced it are held in a result register. A slave error response sets an error flag that stays set until the next read is launched.

A separate rising edge on the store input copies the held {address, data} pair into one of 32 capture slots, chosen by a 5-bit slot index. The slot index also drives the read port of the capture memory, so the selected slot is always visible on two view outputs. Moving the index alone brings back any earlier result. A reset clears the bus state and the flag, but it leaves the stored results in place.

Top module: `apb_rd_capture`

## Requirements
- R1: While reset is low and right after it, psel_o, penable_o, busy_o, err_o and pwrite_o are all 0.
- R2: A 0-to-1 change of start_i while idle and while wsel_i is 0 starts one read. On the next cycle psel_o=1, penable_o=0 and paddr_o equals tgt_addr_i. The cycle after that, psel_o=1 and penable_o=1.
- R3: The access phase, with psel_o=1 and penable_o=1, lasts until pready_i is 1, and paddr_o stays unchanged through it. The cycle after pready_i is sampled high, psel_o and penable_o are 0.
- R4: Keeping start_i high issues only one transaction. A new read needs start_i to go low and then high again.
- R5: busy_o is 1 from the cycle after the start edge through the cycle in which pready_i is sampled high. Start edges that arrive while busy_o is 1 are ignored.
- R6: pwrite_o is always 0. A start edge that arrives while wsel_i is 1 issues no transaction.
- R7: A completion with pslverr_i=1 sets err_o on the next cycle. err_o stays 1 until the next read is launched, and that launch clears it. The data returned with the error is still held.
- R8: A 0-to-1 change of store_i writes the last completed read into slot slot_i. The write stores the address in bits 55:32 and the data in bits 31:0. After the write, view_addr_o and view_data_o show that address and that data.
- R9: view_addr_o and view_data_o show the contents of slot slot_i one clock after slot_i changes. This lets earlier results be read back.
- R10: Keeping store_i high writes only once. A later read does not overwrite the slot until store_i goes low and then high again.
- R11: Reset does not clear the capture memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Read request; its rising edge launches a read |
| wsel_i | input | 1 | Write select; must be 0 for a read to be issued |
| tgt_addr_i | input | 24 | Address to read |
| store_i | input | 1 | Store request; its rising edge writes the held result |
| slot_i | input | 5 | Capture slot to write and to view |
| paddr_o | output | 24 | APB address |
| psel_o | output | 1 | APB select |
| penable_o | output | 1 | APB enable |
| pwrite_o | output | 1 | APB write, held at 0 |
| prdata_i | input | 32 | APB read data |
| pready_i | input | 1 | APB ready |
| pslverr_i | input | 1 | APB slave error |
| busy_o | output | 1 | A read is in progress |
| err_o | output | 1 | Sticky error of the last read |
| view_addr_o | output | 24 | Address stored in the selected slot |
| view_data_o | output | 32 | Data stored in the selected slot |

## Verification
The cases that are hardest to reach from the ports are requests that arrive while a read is still in flight. The bench produces them with a slave model that has a programmable number of wait states. With that model it can pulse start_i again mid-access, or keep start_i high past completion, and then count bus setup phases to confirm that only one transaction occurred. It also keeps store_i high across a later read to show that the slot is written only once. Finally, it pulses reset and reads back an earlier slot to show that the memory kept its contents.

// File: rtl/apb_cap_pkg.sv
package apb_cap_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int SLOT_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2
  } apb_st_e;

  // rising-edge detect of a level against its previous sample
  function automatic logic rise_of(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction
endpackage

// File: rtl/edge_rise.sv
module edge_rise
  import apb_cap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic pulse_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign pulse_o = rise_of(lvl_i, lvl_q);

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/apb_rd_master.sv
module apb_rd_master
  import apb_cap_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] prdata_i,
  input  logic          pready_i,
  input  logic          pslverr_i,
  output logic [AW-1:0] paddr_o,
  output logic          psel_o,
  output logic          penable_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] res_addr_o,
  output logic [DW-1:0] res_data_o,
  output logic          err_o
);
  apb_st_e       st_q;
  logic [AW-1:0] paddr_q, res_addr_q;
  logic [DW-1:0] res_data_q;
  logic          err_q;
  logic          launch;

  assign launch = (st_q == ST_IDLE) && go_i;
  assign done_o = (st_q == ST_ACCESS) && pready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      paddr_q    <= '0;
      res_addr_q <= '0;
      res_data_q <= '0;
      err_q      <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (launch) begin
          st_q    <= ST_SETUP;
          paddr_q <= addr_i;
          err_q   <= 1'b0;
        end
        ST_SETUP: st_q <= ST_ACCESS;
        ST_ACCESS: if (done_o) begin
          st_q       <= ST_IDLE;
          res_addr_q <= paddr_q;
          res_data_q <= prdata_i;
          err_q      <= pslverr_i;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign paddr_o    = paddr_q;
  assign psel_o     = (st_q != ST_IDLE);
  assign penable_o  = (st_q == ST_ACCESS);
  assign busy_o     = psel_o;
  assign res_addr_o = res_addr_q;
  assign res_data_o = res_data_q;
  assign err_o      = err_q;

  // R2
  setup_to_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel_o && !penable_o) |=> (psel_o && penable_o));
  // R3
  access_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (penable_o && !pready_i) |=> (penable_o && $stable(paddr_o)));
  // R3
  access_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (penable_o && pready_i) |=> !psel_o);
  // R5
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && go_i) |=> $stable(paddr_o));
  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && pslverr_i) |=> err_o);
endmodule

// File: rtl/cap_ram.sv
module cap_ram #(
  parameter int SW = 5,
  parameter int EW = 56
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [SW-1:0] wa_i,
  input  logic [EW-1:0] wd_i,
  input  logic [SW-1:0] ra_i,
  output logic [EW-1:0] rd_o
);
  localparam int DEPTH = 1 << SW;

  logic [EW-1:0] mem [DEPTH];
  logic [EW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[wa_i] <= wd_i;
    rd_q <= mem[ra_i];
  end

  assign rd_o = rd_q;

  // R8
  ram_write_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && ra_i == wa_i) ##1 (ra_i == $past(ra_i)) |=> (rd_o == $past(wd_i, 2)));
endmodule

// File: rtl/apb_rd_capture.sv
module apb_rd_capture
  import apb_cap_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int SW = SLOT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          wsel_i,
  input  logic [AW-1:0] tgt_addr_i,
  input  logic          store_i,
  input  logic [SW-1:0] slot_i,
  output logic [AW-1:0] paddr_o,
  output logic          psel_o,
  output logic          penable_o,
  output logic          pwrite_o,
  input  logic [DW-1:0] prdata_i,
  input  logic          pready_i,
  input  logic          pslverr_i,
  output logic          busy_o,
  output logic          err_o,
  output logic [AW-1:0] view_addr_o,
  output logic [DW-1:0] view_data_o
);
  localparam int EW = AW + DW;

  logic          st_rise, sv_rise, go, done;
  logic [AW-1:0] res_addr;
  logic [DW-1:0] res_data;
  logic [EW-1:0] rd_entry;

  edge_rise u_start_edge (.clk(clk), .rst_n(rst_n), .lvl_i(start_i), .pulse_o(st_rise));
  edge_rise u_store_edge (.clk(clk), .rst_n(rst_n), .lvl_i(store_i), .pulse_o(sv_rise));

  assign go = st_rise && !wsel_i;

  apb_rd_master #(.AW(AW), .DW(DW)) u_master (
    .clk(clk), .rst_n(rst_n), .go_i(go), .addr_i(tgt_addr_i),
    .prdata_i(prdata_i), .pready_i(pready_i), .pslverr_i(pslverr_i),
    .paddr_o(paddr_o), .psel_o(psel_o), .penable_o(penable_o),
    .busy_o(busy_o), .done_o(done), .res_addr_o(res_addr),
    .res_data_o(res_data), .err_o(err_o)
  );

  cap_ram #(.SW(SW), .EW(EW)) u_ram (
    .clk(clk), .rst_n(rst_n), .we_i(sv_rise), .wa_i(slot_i),
    .wd_i({res_addr, res_data}), .ra_i(slot_i), .rd_o(rd_entry)
  );

  assign pwrite_o    = 1'b0;
  assign view_addr_o = rd_entry[EW-1:DW];
  assign view_data_o = rd_entry[DW-1:0];

  // R6
  wsel_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rise && wsel_i && !busy_o) |=> !busy_o);
  // R5
  busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done) |=> busy_o);
endmodule

// File: tb/apb_rd_capture_tb.sv
module apb_rd_capture_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start_i, wsel_i, store_i;
  logic [23:0] tgt_addr_i;
  logic [4:0]  slot_i;
  logic [23:0] paddr_o, view_addr_o;
  logic        psel_o, penable_o, pwrite_o, busy_o, err_o;
  logic [31:0] prdata_i, view_data_o;
  logic        pready_i, pslverr_i;

  apb_rd_capture u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wsel_i(wsel_i),
    .tgt_addr_i(tgt_addr_i), .store_i(store_i), .slot_i(slot_i),
    .paddr_o(paddr_o), .psel_o(psel_o), .penable_o(penable_o),
    .pwrite_o(pwrite_o), .prdata_i(prdata_i), .pready_i(pready_i),
    .pslverr_i(pslverr_i), .busy_o(busy_o), .err_o(err_o),
    .view_addr_o(view_addr_o), .view_data_o(view_data_o)
  );

  typedef struct {
    logic [23:0] a;
    logic [31:0] d;
    logic        e;
  } exp_t;

  exp_t expq[$];
  exp_t popped;
  int   checks = 0, errors = 0, txn_cnt = 0, slv_wait = 0, wcnt = 0;
  logic [31:0] slv_data = '0;
  logic        slv_err = 1'b0;
  bit          pw_seen = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model: ready after slv_wait access cycles
  always @(negedge clk) begin
    if (psel_o && penable_o) begin
      if (wcnt >= slv_wait) begin
        pready_i  = 1'b1;
        prdata_i  = slv_data;
        pslverr_i = slv_err;
      end else begin
        pready_i = 1'b0;
        wcnt++;
      end
    end else begin
      pready_i  = 1'b0;
      pslverr_i = 1'b0;
      wcnt      = 0;
    end
  end

  // monitor: scoreboard side
  always @(negedge clk) begin
    #1;
    if (pwrite_o) pw_seen = 1'b1;
    if (psel_o && !penable_o) begin
      txn_cnt++;
      if (expq.size() == 0) chk(1'b0, "R6 unexpected setup", paddr_o, 0);
      else chk(paddr_o == expq[0].a, "R2 setup address", paddr_o, expq[0].a);
    end
    if (psel_o && penable_o && expq.size() > 0)
      chk(paddr_o == expq[0].a, "R3 access address", paddr_o, expq[0].a);
    if (psel_o && penable_o && pready_i && expq.size() > 0) popped = expq.pop_front();
  end

  // mode 0: single pulse, 1: hold high, 2: extra pulse while busy
  task automatic do_read(input logic [23:0] a, input logic [31:0] d, input logic e,
                         input int waits, input int mode);
    expq.push_back('{a, d, e});
    slv_wait = waits; slv_data = d; slv_err = e;
    tgt_addr_i = a; start_i = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b1, "R5 busy after start edge", busy_o, 1);
    if (mode != 1) start_i = 1'b0;
    if (mode == 2) begin
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    chk(err_o == e, "R7 error flag after read", err_o, e);
    if (mode == 1) begin
      repeat (3) @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic store_to(input logic [4:0] s);
    slot_i = s; store_i = 1'b1;
    @(negedge clk);
    store_i = 1'b0;
  endtask

  task automatic view(input logic [4:0] s, input logic [23:0] a, input logic [31:0] d, input string req);
    slot_i = s;
    @(negedge clk);
    chk(view_addr_o == a, req, view_addr_o, a);
    chk(view_data_o == d, req, view_data_o, d);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int b;
    rst_n = 1'b0; start_i = 0; wsel_i = 0; store_i = 0; tgt_addr_i = '0; slot_i = '0;
    pready_i = 0; prdata_i = '0; pslverr_i = 0;
    repeat (3) @(negedge clk);
    // R1
    chk({psel_o, penable_o, busy_o, err_o, pwrite_o} == 5'b0, "R1 reset outputs",
        {psel_o, penable_o, busy_o, err_o, pwrite_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({psel_o, penable_o, busy_o, err_o} == 4'b0, "R1 after reset", {psel_o, penable_o, busy_o, err_o}, 0);

    // R2 R8: plain read, store, view
    do_read(24'hC00200, 32'h0009_1003, 1'b0, 0, 0);
    store_to(5'd1);
    view(5'd1, 24'hC00200, 32'h0009_1003, "R8 stored pair slot 1");

    // R3: wait states
    do_read(24'h000010, 32'hDEAD_BEEF, 1'b0, 3, 0);
    store_to(5'd2);
    view(5'd2, 24'h000010, 32'hDEAD_BEEF, "R8 stored pair slot 2");

    // R9: revisit earlier slot, one-cycle latency
    view(5'd1, 24'hC00200, 32'h0009_1003, "R9 earlier slot 1");
    view(5'd2, 24'h000010, 32'hDEAD_BEEF, "R9 earlier slot 2");

    // R4: start held high
    b = txn_cnt;
    do_read(24'h123456, 32'h0000_00A5, 1'b0, 1, 1);
    chk(txn_cnt == b + 1, "R4 held start single txn", txn_cnt, b + 1);

    // R5: extra pulse while busy
    b = txn_cnt;
    do_read(24'h00BEEF, 32'h5555_AAAA, 1'b0, 6, 2);
    repeat (3) @(negedge clk);
    chk(txn_cnt == b + 1, "R5 edge while busy ignored", txn_cnt, b + 1);

    // R7: slave error, sticky, data held
    do_read(24'hABCDEF, 32'h1234_5678, 1'b1, 1, 0);
    repeat (3) @(negedge clk);
    chk(err_o == 1'b1, "R7 error stays set", err_o, 1);
    store_to(5'd5);
    view(5'd5, 24'hABCDEF, 32'h1234_5678, "R7 data held with error");
    do_read(24'h000004, 32'h0000_0001, 1'b0, 0, 0);

    // R6: write select blocks the read
    b = txn_cnt;
    wsel_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0, "R6 no busy with wsel", busy_o, 0);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(txn_cnt == b, "R6 no txn with wsel", txn_cnt, b);
    wsel_i = 1'b0;
    chk(pw_seen == 1'b0, "R6 pwrite never high", pw_seen, 0);

    // R10: store held high writes once
    slot_i = 5'd7; store_i = 1'b1;
    @(negedge clk);
    do_read(24'h00F00D, 32'hCAFE_0001, 1'b0, 0, 0);
    store_i = 1'b0;
    @(negedge clk);
    view(5'd7, 24'h000004, 32'h0000_0001, "R10 held store single write");

    // R11: reset keeps memory
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk({psel_o, busy_o, err_o} == 3'b0, "R1 reset mid-run", {psel_o, busy_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    view(5'd1, 24'hC00200, 32'h0009_1003, "R11 memory kept over reset");

    chk(expq.size() == 0, "R2 all expected reads seen", expq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule